// File: doc/BRIEF.md
# Integer ALU with Packed Status Word

This block is the arithmetic and logic stage of a 16-bit integer datapath that can also work on single bytes. Each clock it accepts two operands, a 4-bit operation code, a width select and an incoming carry. One clock later it presents the result, a write strobe for the destination register and a complete 16-bit status word.

The status word holds six condition bits derived from the result: carry/borrow, even parity of the low byte, half carry, zero, sign and signed overflow. Three control bits (single-step, interrupt enable, string direction) are copied from a separate input, and the remaining positions carry fixed values. Compare and test produce flags only. Opcodes outside the defined set leave the destination and the condition bits untouched.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry; carry_i is added only for opcode 1) give result = A + B (+ carry) modulo the selected width, and status bit 0 is 1 exactly when an unsigned carry leaves the top bit of the selected width.
- R2: Opcodes 2 (subtract), 3 (subtract with borrow; carry_i is subtracted only for opcode 3) and 4 (compare) give A - B (- borrow) modulo the width, and status bit 0 is 1 exactly when an unsigned borrow occurs.
- R3: Status bit 4 is 1 when add or subtract produces a carry or borrow from bit 3 into bit 4; it is 0 for logic opcodes.
- R4: Status bit 6 is 1 when the result within the selected width is zero, and status bit 7 equals the top bit of the selected width of the result.
- R5: Status bit 2 is 1 when the low 8 bits of the result hold an even number of ones, and 0 when odd.
- R6: Status bit 11 is 1 when the two's-complement result of add or subtract falls outside the signed range of the selected width.
- R7: res_we_o is 0 after opcodes 4 (compare) and 8 (test), and 1 after opcodes 0 to 3 and 5 to 7.
- R8: Opcodes 5 (AND), 6 (OR), 7 (XOR) and 8 (test, computed as AND) give the bitwise result and clear status bits 0, 4 and 11.
- R9: With wide_i = 0 the operation uses bits 7:0 only, result bits 15:8 copy opa_i bits 15:8, and carry, sign, zero and overflow refer to the 8-bit result; wide_i = 1 uses all 16 bits.
- R10: Status bits 8, 9 and 10 equal ctl_i bits 0, 1 and 2 of the same input cycle; bit 1 reads 1, bits 3 and 5 read 0, bits 15:12 read 1.
- R11: Opcodes 9 to 15 leave res_o unchanged, give res_we_o = 0 and keep status bits 0, 2, 4, 6, 7 and 11 at their previous values.
- R12: While rst_n is low, res_o is 0, res_we_o is 0 and flags_o is 16'hF002.
- R13: Every output reflects the inputs sampled at the previous rising clock edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opa_i | input | 16 | First operand (destination value) |
| opb_i | input | 16 | Second operand |
| carry_i | input | 1 | Incoming carry or borrow |
| ctl_i | input | 3 | Control bits copied into the status word |
| res_o | output | 16 | Registered result |
| res_we_o | output | 1 | Destination write strobe |
| flags_o | output | 16 | Registered status word |

## Verification
The result, the write strobe and the status word all appear exactly one rising edge after the inputs are applied, and every value goes through a single register stage. The bench applies each stimulus on a falling edge and samples one time unit after the following rising edge, so each check sees the response to exactly one input vector. A dedicated check samples just before that edge to show that the outputs still hold the previous response. Held state for undefined opcodes is compared against the response the bench expects from the vector before.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_CMP  = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_TEST = 4'd8
   } alu_op_e;

   localparam int STAT_W = 16;

   localparam int FB_C = 0;
   localparam int FB_P = 2;
   localparam int FB_A = 4;
   localparam int FB_Z = 6;
   localparam int FB_S = 7;
   localparam int FB_T = 8;
   localparam int FB_I = 9;
   localparam int FB_D = 10;
   localparam int FB_O = 11;

   localparam logic [STAT_W-1:0] STAT_FIXED  = 16'hF002;
   localparam logic [STAT_W-1:0] STAT_CTL_M  = 16'h0700;
   localparam logic [STAT_W-1:0] STAT_COND_M = 16'h08D5;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_sel_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   input  logic          sub,
   input  logic          wide,
   output logic [DW-1:0] r,
   output logic          cf,
   output logic          af,
   output logic          of
);

   localparam int MSB_W = DW - 1;
   localparam int MSB_B = BW - 1;

   if (BW < 5 || BW >= DW) begin : g_bad_bw
      $error("alu_arith: byte lane width must be 5..DW-1");
   end

   logic [DW:0] wsum;
   logic [BW:0] bsum;
   logic        c_top;

   always_comb begin
      if (sub) begin
         wsum = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
         bsum = {1'b0, a[BW-1:0]} - {1'b0, b[BW-1:0]} - {{BW{1'b0}}, cin};
      end else begin
         wsum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
         bsum = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]} + {{BW{1'b0}}, cin};
      end
      if (wide) begin
         r     = wsum[DW-1:0];
         cf    = wsum[DW];
         c_top = a[MSB_W] ^ b[MSB_W] ^ wsum[MSB_W];
      end else begin
         r     = {a[DW-1:BW], bsum[BW-1:0]};
         cf    = bsum[BW];
         c_top = a[MSB_B] ^ b[MSB_B] ^ bsum[MSB_B];
      end
      // carry (or borrow) entering bit 4
      af = a[4] ^ b[4] ^ r[4];
      // signed overflow: carry into top bit differs from carry out of it
      of = c_top ^ cf;
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_flag_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic_sel_e    sel,
   output logic [DW-1:0] r
);

   always_comb begin
      unique case (sel)
         LG_OR:   r = a | b;
         LG_XOR:  r = a ^ b;
         default: r = a & b;
      endcase
   end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
   import alu_flag_pkg::*;
#(
   parameter int DW    = 16,
   parameter int BW    = 8,
   parameter int PAR_W = 8
) (
   input  logic [DW-1:0]     r,
   input  logic              wide,
   input  logic              cf,
   input  logic              af,
   input  logic              of,
   input  logic [2:0]        ctl,
   output logic [STAT_W-1:0] word
);

   if (PAR_W < 1 || PAR_W > BW) begin : g_bad_par
      $error("alu_flags: parity span must be 1..BW");
   end

   logic [PAR_W-1:0] pchain;

   for (genvar i = 0; i < PAR_W; i++) begin : g_par
      if (i == 0) begin : g_first
         assign pchain[i] = r[0];
      end else begin : g_next
         assign pchain[i] = pchain[i-1] ^ r[i];
      end
   end

   logic zf, sf, pf;

   always_comb begin
      zf = wide ? (r == '0) : (r[BW-1:0] == '0);
      sf = wide ? r[DW-1] : r[BW-1];
      pf = ~pchain[PAR_W-1];

      word       = STAT_FIXED;
      word[FB_C] = cf;
      word[FB_P] = pf;
      word[FB_A] = af;
      word[FB_Z] = zf;
      word[FB_S] = sf;
      word[FB_T] = ctl[0];
      word[FB_I] = ctl[1];
      word[FB_D] = ctl[2];
      word[FB_O] = of;
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DW    = 16,
   parameter int PAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic              wide_i,
   input  logic [DW-1:0]     opa_i,
   input  logic [DW-1:0]     opb_i,
   input  logic              carry_i,
   input  logic [2:0]        ctl_i,
   output logic [DW-1:0]     res_o,
   output logic              res_we_o,
   output logic [STAT_W-1:0] flags_o
);

   localparam int BW = DW / 2;

   if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
      $error("alu_flag_unit: DW must be a multiple of 8 and at least 16");
   end

   // ---------------- decode ----------------
   logic       is_arith, is_logic, is_sub, use_c, no_wr, valid;
   logic_sel_e lsel;

   always_comb begin
      is_arith = (op_i == OP_ADD) || (op_i == OP_ADC) || (op_i == OP_SUB) ||
                 (op_i == OP_SBB) || (op_i == OP_CMP);
      is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                 (op_i == OP_TEST);
      is_sub   = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
      use_c    = (op_i == OP_ADC) || (op_i == OP_SBB);
      no_wr    = (op_i == OP_CMP) || (op_i == OP_TEST);
      valid    = is_arith || is_logic;
      if (op_i == OP_OR)       lsel = LG_OR;
      else if (op_i == OP_XOR) lsel = LG_XOR;
      else                     lsel = LG_AND;
   end

   // ---------------- datapath ----------------
   logic [DW-1:0] ar, lr, lr_w, rsel;
   logic          a_cf, a_af, a_of;
   logic          s_cf, s_af, s_of;

   alu_arith #(.DW(DW), .BW(BW)) u_arith (
      .a    (opa_i),
      .b    (opb_i),
      .cin  (carry_i & use_c),
      .sub  (is_sub),
      .wide (wide_i),
      .r    (ar),
      .cf   (a_cf),
      .af   (a_af),
      .of   (a_of)
   );

   alu_logic #(.DW(DW)) u_logic (
      .a   (opa_i),
      .b   (opb_i),
      .sel (lsel),
      .r   (lr)
   );

   always_comb begin
      lr_w = wide_i ? lr : {opa_i[DW-1:BW], lr[BW-1:0]};
      rsel = is_arith ? ar : lr_w;
      s_cf = is_arith & a_cf;
      s_af = is_arith & a_af;
      s_of = is_arith & a_of;
   end

   logic [STAT_W-1:0] fw;

   alu_flags #(.DW(DW), .BW(BW), .PAR_W(PAR_W)) u_flags (
      .r    (rsel),
      .wide (wide_i),
      .cf   (s_cf),
      .af   (s_af),
      .of   (s_of),
      .ctl  (ctl_i),
      .word (fw)
   );

   // ---------------- output registers ----------------
   logic [STAT_W-1:0] flags_d;

   always_comb begin
      if (valid) begin
         flags_d = fw;
      end else begin
         flags_d       = flags_o;
         flags_d[FB_T] = ctl_i[0];
         flags_d[FB_I] = ctl_i[1];
         flags_d[FB_D] = ctl_i[2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o    <= '0;
         res_we_o <= 1'b0;
         flags_o  <= STAT_FIXED;
      end else begin
         if (valid) res_o <= rsel;
         res_we_o <= valid & ~no_wr;
         flags_o  <= flags_d;
      end
   end

   // ---------------- assertions ----------------
   // R7: compare and test never request a destination write
   a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past((op_i == OP_CMP) || (op_i == OP_TEST))) |-> !res_we_o);

   // R8: logic results leave carry, half carry and overflow clear
   a_r8_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past((op_i >= 4'd5) && (op_i <= 4'd8)))
      |-> (!flags_o[FB_C] && !flags_o[FB_A] && !flags_o[FB_O]));

   // R5: parity bit agrees with the registered result's low byte
   a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_i <= 4'd8) && $past(op_i != OP_CMP))
      |-> (flags_o[FB_P] == ~^res_o[7:0]));

   // R10: control bits follow the previous cycle's input
   a_r10_ctl: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (flags_o[FB_D:FB_T] == $past(ctl_i)));

   // R11: undefined opcodes keep condition bits and result
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_i > 4'd8))
      |-> (((flags_o & STAT_COND_M) == ($past(flags_o) & STAT_COND_M)) &&
           $stable(res_o) && !res_we_o));

endmodule

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic        wide_i = 1'b0;
   logic [15:0] opa_i = '0;
   logic [15:0] opb_i = '0;
   logic        carry_i = 1'b0;
   logic [2:0]  ctl_i = '0;
   logic [15:0] res_o;
   logic        res_we_o;
   logic [15:0] flags_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   int exp_res   = 0;
   int exp_flags = 16'hF002;

   always #(CLK_P/2) clk = ~clk;

   alu_flag_unit u_alu_flag_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_i),
      .wide_i   (wide_i),
      .opa_i    (opa_i),
      .opb_i    (opb_i),
      .carry_i  (carry_i),
      .ctl_i    (ctl_i),
      .res_o    (res_o),
      .res_we_o (res_we_o),
      .flags_o  (flags_o)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(input int v, input int w);
      return (v >= (1 << (w-1))) ? v - (1 << w) : v;
   endfunction

   function automatic int bit_of(input int v, input int n);
      return (v >> n) & 1;
   endfunction

   task automatic run_op(input int op, input int wide, input int a, input int b,
                         input int cin, input int ctl);
      int w, mask, half, ua, ub, c, t, ra, full, cf, af, of, zf, sf, pf, sres, ones, we;
      string tg;
      @(negedge clk);
      op_i = op[3:0]; wide_i = wide[0]; opa_i = a[15:0]; opb_i = b[15:0];
      carry_i = cin[0]; ctl_i = ctl[2:0];
      @(posedge clk);
      #1;
      w = wide ? 16 : 8;
      mask = (1 << w) - 1;
      half = 1 << (w-1);
      ua = a & mask; ub = b & mask;
      c = (op == 1 || op == 3) ? cin : 0;
      cf = 0; af = 0; of = 0; ra = 0;
      if (op <= 1) begin
         t = ua + ub + c; cf = (t > mask) ? 1 : 0; ra = t & mask;
         af = (((ua & 15) + (ub & 15) + c) > 15) ? 1 : 0;
         sres = sx(ua, w) + sx(ub, w) + c;
         of = (sres > half - 1 || sres < -half) ? 1 : 0;
      end else if (op <= 4) begin
         t = ua - ub - c; cf = (t < 0) ? 1 : 0; ra = t & mask;
         af = (((ua & 15) - (ub & 15) - c) < 0) ? 1 : 0;
         sres = sx(ua, w) - sx(ub, w) - c;
         of = (sres > half - 1 || sres < -half) ? 1 : 0;
      end else if (op == 5 || op == 8) ra = ua & ub;
      else if (op == 6) ra = ua | ub;
      else if (op == 7) ra = ua ^ ub;

      if (op > 8) begin
         // R11: undefined opcode holds everything but the control bits
         exp_flags = (exp_flags & ~16'h0700) | (ctl << 8);
         chk("R11", "result held", int'(res_o), exp_res);
         chk("R11", "no write", int'(res_we_o), 0);
         chk("R11", "flags held", int'(flags_o), exp_flags);
         return;
      end

      full = wide ? ra : ((a & 16'hFF00) | ra);
      zf = (ra == 0) ? 1 : 0;
      sf = bit_of(ra, w-1);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += bit_of(full, i);
      pf = (ones % 2 == 0) ? 1 : 0;
      we = (op == 4 || op == 8) ? 0 : 1;
      exp_res = full;
      exp_flags = 16'hF002 | cf | (pf << 2) | (af << 4) | (zf << 6) | (sf << 7) |
                  (ctl << 8) | (of << 11);

      tg = (op <= 1) ? "R1" : (op <= 4) ? "R2" : "R8";
      if (!wide) chk("R9", "byte result with upper copy", int'(res_o), full);
      else       chk(tg, "word result", int'(res_o), full);
      chk("R7", "write strobe", int'(res_we_o), we);
      chk(tg, "carry bit0", int'(flags_o[0]), cf);
      chk("R3", "half carry bit4", int'(flags_o[4]), af);
      chk("R4", "zero bit6", int'(flags_o[6]), zf);
      chk("R4", "sign bit7", int'(flags_o[7]), sf);
      chk("R5", "parity bit2", int'(flags_o[2]), pf);
      chk("R6", "overflow bit11", int'(flags_o[11]), of);
      chk("R10", "control bits 10:8", int'(flags_o[10:8]), ctl);
      chk("R10", "fixed bits", int'(flags_o & 16'hF02A), 16'hF002);
   endtask

   initial begin
      #(CLK_P * 190000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int corners [12];
      corners = '{0, 1, 2, 16'h000F, 16'h0010, 16'h007F, 16'h0080, 16'h00FF,
                  16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
      // R12: reset state
      op_i = 4'd0; opa_i = 16'h1234; opb_i = 16'h4321; ctl_i = 3'b111;
      repeat (3) @(posedge clk);
      #1;
      chk("R12", "reset result", int'(res_o), 0);
      chk("R12", "reset strobe", int'(res_we_o), 0);
      chk("R12", "reset flags", int'(flags_o), 16'hF002);
      @(negedge clk);
      rst_n = 1'b1;

      // R13: outputs change only at the edge after the stimulus
      run_op(0, 1, 16'h0100, 16'h0023, 0, 0);
      @(negedge clk);
      op_i = 4'd0; wide_i = 1'b1; opa_i = 16'h2000; opb_i = 16'h0005; ctl_i = 3'd5;
      #1;
      chk("R13", "result before edge", int'(res_o), 16'h0123);
      chk("R13", "flags before edge", int'(flags_o), exp_flags);
      @(posedge clk);
      #1;
      chk("R13", "result after edge", int'(res_o), 16'h2005);
      exp_res = 16'h2005;
      exp_flags = 16'hF002 | (1 << 2) | (5 << 8);
      chk("R13", "flags after edge", int'(flags_o), exp_flags);

      // byte-mode sweep over all first operands and 16 second operands
      for (int op = 0; op <= 8; op++)
         for (int cin = 0; cin <= 1; cin++)
            for (int a = 0; a < 256; a++)
               for (int bi = 0; bi < 16; bi++)
                  run_op(op, 0, (((a * 37) & 255) << 8) | a,
                         (((bi * 91) & 255) << 8) | (bi * 17), cin, a & 7);

      // word-mode corner sweep
      for (int op = 0; op <= 8; op++)
         for (int cin = 0; cin <= 1; cin++)
            for (int i = 0; i < 12; i++)
               for (int j = 0; j < 12; j++)
                  run_op(op, 1, corners[i], corners[j], cin, (i + j) & 7);

      // R11: undefined opcodes after a known result
      for (int op = 9; op <= 15; op++) begin
         run_op(2, 1, 16'h0005, 16'h0007, 0, 1);
         run_op(op, 1, 16'hAAAA, 16'h5555, 1, op & 7);
         run_op(op, 0, 16'h00FF, 16'h0001, 0, 3);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule